// File: doc/BRIEF.md
# Accumulating ALU with Input Scaling

This block is the arithmetic heart of a fixed-point datapath. It holds a 32-bit accumulator and runs one command per clock. One operand always comes from the accumulator. The other operand is either a 32-bit product that the multiplier has already scaled, or a 16-bit data word. A data word is widened to 32 bits and then shifted left by a 4-bit amount taken from the low nibble of the multiplier's temporary register. Every command writes its result back into the accumulator.

Beyond load, add and subtract, the block has three further kinds of command. Bitwise commands combine the accumulator with a data word. A normalize command removes one redundant sign bit each time it is issued, so firmware repeats it until the done flag rises. A bit-test command copies one selected bit of a data word into a test flag. Add and subtract report an unsigned carry, which is kept for extended-precision sequences.

Top module: `scaled_acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, `carry_out`, `tbit_out` and `norm_done` become 0 after that edge.
- R2: Command 4'h1 (load data) sets the accumulator to the widened data word shifted left by `shamt` (0 to 15). The word is widened by sign extension from bit 15, or by zero extension when `sx_off` is 1.
- R3: Command 4'h2 (add data) adds the same shifted word to the accumulator, modulo 2^32. `carry_out` takes the carry out of bit 31.
- R4: Command 4'h3 (subtract data) subtracts the same shifted word from the accumulator, modulo 2^32. `carry_out` is 1 when no borrow occurs (accumulator >= operand, unsigned) and 0 otherwise.
- R5: Commands 4'h4, 4'h5 and 4'h6 load, add and subtract `prod_in` unshifted. `carry_out` is set as in R3 and R4.
- R6: Commands 4'h7, 4'h8 and 4'h9 compute AND, OR and XOR with the zero-extended 16-bit data word. AND therefore clears bits 31..16. OR and XOR leave bits 31..16 unchanged.
- R7: Command 4'hA (normalize) acts on bits 31 and 30 of the accumulator. If they are equal, it shifts the accumulator left by one and clears `norm_done`. If they differ, it leaves the accumulator unchanged and sets `norm_done`.
- R8: Command 4'hB (bit test) sets `tbit_out` to bit (15 - `shamt`) of `data_in`, so index 0 selects the most significant bit.
- R9: The following change nothing: `op_valid` low, or a code of 4'h0 or 4'hC to 4'hF. `carry_out` changes only on add or subtract commands. `tbit_out` changes only on bit test. `norm_done` changes only on normalize.
- R10: Each result appears on the outputs right after the clock edge that samples the command, so back-to-back commands chain through the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 4 | Command code |
| data_in | input | 16 | Data word operand |
| prod_in | input | 32 | Scaled product operand |
| shamt | input | 4 | Low nibble of temporary register: shift amount or bit index |
| sx_off | input | 1 | Suppress sign extension of the data word |
| acc_out | output | 32 | Accumulator |
| carry_out | output | 1 | Carry/no-borrow of last add or subtract |
| tbit_out | output | 1 | Result of last bit test |
| norm_done | output | 1 | Last normalize found the accumulator normalized |

## Verification
Every result, including the accumulator, carry, test bit and normalize flag, is registered once. A result is therefore due one clock after the edge that samples the command. The bench drives each command on a falling edge and removes it on the next falling edge, then compares all four outputs at that moment, when the single rising edge in between has updated them. Normalize runs are issued one command per cycle, and the bench checks both the value after each step and the number of steps before the flag rises.

// File: rtl/scaled_acc_pkg.sv
package scaled_acc_pkg;
    localparam int DATA_W  = 16;
    localparam int ACC_W   = 32;
    localparam int SHAMT_W = 4;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'h0,
        CMD_LDD   = 4'h1,
        CMD_ADDD  = 4'h2,
        CMD_SUBD  = 4'h3,
        CMD_LDP   = 4'h4,
        CMD_ADDP  = 4'h5,
        CMD_SUBP  = 4'h6,
        CMD_AND   = 4'h7,
        CMD_OR    = 4'h8,
        CMD_XOR   = 4'h9,
        CMD_NORM  = 4'hA,
        CMD_BTEST = 4'hB
    } cmd_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             carry;
        logic             tbit;
        logic             ndone;
    } alu_state_t;

    function automatic logic is_arith(input logic [3:0] c);
        return (c == CMD_ADDD) || (c == CMD_SUBD) || (c == CMD_ADDP) || (c == CMD_SUBP);
    endfunction
endpackage

// File: rtl/in_scaler.sv
module in_scaler #(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic [DW-1:0] word,
    input  logic          no_sext,
    input  logic [SW-1:0] amount,
    output logic [AW-1:0] scaled
);
    localparam int PAD = AW - DW;
    logic [AW-1:0] widened;

    always_comb begin
        widened = {{PAD{word[DW-1] & ~no_sext}}, word};
        scaled  = widened << amount;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import scaled_acc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic [3:0]    cmd,
    input  alu_state_t    cur,
    input  logic [AW-1:0] scaled,
    input  logic [AW-1:0] prod,
    input  logic [DW-1:0] word,
    input  logic [SW-1:0] idx,
    output alu_state_t    nxt
);
    localparam int PAD = AW - DW;
    logic [AW-1:0] opnd;
    logic [AW-1:0] wz;
    logic [AW:0]   sum;
    logic [AW:0]   dif;
    logic [DW-1:0] probe;
    logic          use_prod;

    always_comb begin
        use_prod = (cmd == CMD_LDP) || (cmd == CMD_ADDP) || (cmd == CMD_SUBP);
        opnd     = use_prod ? prod : scaled;
        wz       = {{PAD{1'b0}}, word};
        sum      = {1'b0, cur.acc} + {1'b0, opnd};
        dif      = {1'b0, cur.acc} + {1'b0, ~opnd} + {{AW{1'b0}}, 1'b1};
        probe    = word << idx;
        nxt      = cur;
        case (cmd)
            CMD_LDD, CMD_LDP:   nxt.acc = opnd;
            CMD_ADDD, CMD_ADDP: begin
                nxt.acc   = sum[AW-1:0];
                nxt.carry = sum[AW];
            end
            CMD_SUBD, CMD_SUBP: begin
                nxt.acc   = dif[AW-1:0];
                nxt.carry = dif[AW];
            end
            CMD_AND: nxt.acc = cur.acc & wz;
            CMD_OR:  nxt.acc = cur.acc | wz;
            CMD_XOR: nxt.acc = cur.acc ^ wz;
            CMD_NORM: begin
                if (cur.acc[AW-1] == cur.acc[AW-2]) begin
                    nxt.acc   = cur.acc << 1;
                    nxt.ndone = 1'b0;
                end else begin
                    nxt.ndone = 1'b1;
                end
            end
            CMD_BTEST: nxt.tbit = probe[DW-1];
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/scaled_acc_alu.sv
module scaled_acc_alu
    import scaled_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic [DATA_W-1:0]  data_in,
    input  logic [ACC_W-1:0]   prod_in,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sx_off,
    output logic [ACC_W-1:0]   acc_out,
    output logic               carry_out,
    output logic               tbit_out,
    output logic               norm_done
);
    alu_state_t     st_q;
    alu_state_t     st_d;
    logic [ACC_W-1:0] scaled_w;
    logic [3:0]     cmd_eff;

    assign cmd_eff = op_valid ? op_code : CMD_NOP;

    in_scaler #(.DW(DATA_W), .AW(ACC_W), .SW(SHAMT_W)) u_scale (
        .word    (data_in),
        .no_sext (sx_off),
        .amount  (shamt),
        .scaled  (scaled_w)
    );

    alu_core #(.DW(DATA_W), .AW(ACC_W), .SW(SHAMT_W)) u_core (
        .cmd    (cmd_eff),
        .cur    (st_q),
        .scaled (scaled_w),
        .prod   (prod_in),
        .word   (data_in),
        .idx    (shamt),
        .nxt    (st_d)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_out   = st_q.acc;
    assign carry_out = st_q.carry;
    assign tbit_out  = st_q.tbit;
    assign norm_done = st_q.ndone;
endmodule

// File: rtl/scaled_acc_alu_chk.sv
module scaled_acc_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic [31:0] acc_out,
    input logic        carry_out,
    input logic        tbit_out,
    input logic        norm_done
);
    logic is_norm, is_btest, is_arith;
    assign is_norm  = op_valid && (op_code == 4'hA);
    assign is_btest = op_valid && (op_code == 4'hB);
    assign is_arith = op_valid && (op_code == 4'h2 || op_code == 4'h3 ||
                                   op_code == 4'h5 || op_code == 4'h6);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_out == 32'h0) && !carry_out && !tbit_out && !norm_done);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc_out) && $stable(carry_out) && $stable(tbit_out) && $stable(norm_done));

    a_r7_norm_shifts: assert property (@(posedge clk) disable iff (rst)
        (is_norm && (acc_out[31] == acc_out[30])) |=> (acc_out == ($past(acc_out) << 1)) && !norm_done);

    a_r7_norm_stops: assert property (@(posedge clk) disable iff (rst)
        (is_norm && (acc_out[31] != acc_out[30])) |=> $stable(acc_out) && norm_done);

    a_r9_tbit_only_btest: assert property (@(posedge clk) disable iff (rst)
        !is_btest |=> $stable(tbit_out));

    a_r9_carry_only_arith: assert property (@(posedge clk) disable iff (rst)
        !is_arith |=> $stable(carry_out));
endmodule

bind scaled_acc_alu scaled_acc_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .acc_out   (acc_out),
    .carry_out (carry_out),
    .tbit_out  (tbit_out),
    .norm_done (norm_done)
);

// File: tb/scaled_acc_alu_test.sv
`timescale 1ns/1ps
module scaled_acc_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'h0;
    logic [15:0] data_in = 16'h0;
    logic [31:0] prod_in = 32'h0;
    logic [3:0]  shamt = 4'h0;
    logic        sx_off = 1'b0;
    logic [31:0] acc_out;
    logic        carry_out, tbit_out, norm_done;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_acc = 32'h0;
    logic        m_c = 1'b0, m_t = 1'b0, m_n = 1'b0;

    always #2.5 clk = ~clk;

    scaled_acc_alu uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .data_in(data_in), .prod_in(prod_in), .shamt(shamt), .sx_off(sx_off),
        .acc_out(acc_out), .carry_out(carry_out), .tbit_out(tbit_out), .norm_done(norm_done)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "acc", acc_out, m_acc);
        check(req, "carry", {31'h0, carry_out}, {31'h0, m_c});
        check(req, "tbit", {31'h0, tbit_out}, {31'h0, m_t});
        check(req, "ndone", {31'h0, norm_done}, {31'h0, m_n});
    endtask

    // issued at a falling edge; results compared one rising edge later
    task automatic run_op(input string req, input logic v, input logic [3:0] op,
                          input logic [15:0] d, input logic [31:0] p,
                          input logic [3:0] sh, input logic sx);
        logic [31:0] ext, sc, opn;
        logic [32:0] w;
        op_valid = v; op_code = op; data_in = d; prod_in = p; shamt = sh; sx_off = sx;
        @(negedge clk);
        op_valid = 1'b0;
        ext = sx ? {16'h0, d} : {{16{d[15]}}, d};
        sc  = ext << sh;
        opn = (op >= 4'h4 && op <= 4'h6) ? p : sc;
        if (v) begin
            case (op)
                4'h1, 4'h4: m_acc = opn;
                4'h2, 4'h5: begin w = {1'b0, m_acc} + {1'b0, opn}; m_acc = w[31:0]; m_c = w[32]; end
                4'h3, 4'h6: begin m_c = (m_acc >= opn); m_acc = m_acc - opn; end
                4'h7: m_acc = m_acc & {16'h0, d};
                4'h8: m_acc = m_acc | {16'h0, d};
                4'h9: m_acc = m_acc ^ {16'h0, d};
                4'hA: begin
                    if (m_acc[31] == m_acc[30]) begin m_acc = m_acc << 1; m_n = 1'b0; end
                    else m_n = 1'b1;
                end
                4'hB: m_t = d[4'd15 - sh];
                default: ;
            endcase
        end
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] dl [6];
        logic [31:0] pl [4];
        int steps;
        dl[0] = 16'h8000; dl[1] = 16'h7FFF; dl[2] = 16'h0001;
        dl[3] = 16'hFFFF; dl[4] = 16'h1234; dl[5] = 16'hA5A5;
        pl[0] = 32'h0; pl[1] = 32'hFFFFFFFF; pl[2] = 32'h80000000; pl[3] = 32'h12345678;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2 R3 R4: sweep shift amounts, extension mode and data
        for (int sh = 0; sh < 16; sh++)
            for (int sx = 0; sx < 2; sx++)
                for (int i = 0; i < 6; i++) begin
                    run_op("R2", 1'b1, 4'h1, dl[i], 32'h0, sh[3:0], sx[0]);
                    run_op("R3", 1'b1, 4'h2, dl[(i+1)%6], 32'h0, sh[3:0], sx[0]);
                    run_op("R4", 1'b1, 4'h3, dl[(i+3)%6], 32'h0, sh[3:0], sx[0]);
                end
        // R4 boundary: equal operands give no borrow
        run_op("R4", 1'b1, 4'h1, 16'h0005, 32'h0, 4'h0, 1'b0);
        run_op("R4", 1'b1, 4'h3, 16'h0005, 32'h0, 4'h0, 1'b0);
        run_op("R4", 1'b1, 4'h3, 16'h0001, 32'h0, 4'h0, 1'b0);

        // R5 product path
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                run_op("R5", 1'b1, 4'h4, 16'h0, pl[a], 4'hF, 1'b0);
                run_op("R5", 1'b1, 4'h5, 16'hFFFF, pl[b], 4'h7, 1'b0);
                run_op("R5", 1'b1, 4'h6, 16'h0, pl[(a+b)%4], 4'h3, 1'b0);
            end

        // R6 Boolean ops; carry must stay (R9)
        for (int i = 0; i < 6; i++) begin
            run_op("R6", 1'b1, 4'h4, 16'h0, 32'hDEADBEEF, 4'h0, 1'b0);
            run_op("R6", 1'b1, 4'h8, dl[i], 32'h0, 4'h5, 1'b0);
            run_op("R6", 1'b1, 4'h9, dl[(i+2)%6], 32'h0, 4'h9, 1'b0);
            run_op("R6", 1'b1, 4'h7, dl[(i+4)%6], 32'h0, 4'h2, 1'b0);
        end

        // R8 bit test on every index
        for (int i = 0; i < 6; i++)
            for (int sh = 0; sh < 16; sh++)
                run_op("R8", 1'b1, 4'hB, dl[i], 32'h0, sh[3:0], 1'b0);

        // R7 normalize from +1: 30 shifts then done
        run_op("R7", 1'b1, 4'h1, 16'h0001, 32'h0, 4'h0, 1'b0);
        steps = 0;
        for (int k = 0; k < 40; k++) begin
            run_op("R7", 1'b1, 4'hA, 16'h0, 32'h0, 4'h0, 1'b0);
            if (norm_done) break;
            steps++;
        end
        check("R7", "steps from +1", steps, 30);
        run_op("R7", 1'b1, 4'hA, 16'h0, 32'h0, 4'h0, 1'b0);
        // R7 from -1: 31 shifts then done
        run_op("R7", 1'b1, 4'h1, 16'hFFFF, 32'h0, 4'h0, 1'b0);
        steps = 0;
        for (int k = 0; k < 40; k++) begin
            run_op("R7", 1'b1, 4'hA, 16'h0, 32'h0, 4'h0, 1'b0);
            if (norm_done) break;
            steps++;
        end
        check("R7", "steps from -1", steps, 31);
        check("R7", "final acc", acc_out, 32'h80000000);

        // R9 idle and unused codes leave everything unchanged
        run_op("R9", 1'b1, 4'h2, 16'hFFFF, 32'h0, 4'h0, 1'b1);
        run_op("R9", 1'b0, 4'h1, 16'h4321, 32'h0, 4'h0, 1'b0);
        run_op("R9", 1'b0, 4'h2, 16'h7777, 32'h0, 4'h4, 1'b0);
        for (int c = 12; c < 16; c++)
            run_op("R9", 1'b1, c[3:0], 16'hFFFF, 32'hFFFFFFFF, 4'hF, 1'b0);
        run_op("R9", 1'b1, 4'h0, 16'hFFFF, 32'hFFFFFFFF, 4'hF, 1'b0);

        // R10 back-to-back chaining with a one-cycle result
        run_op("R10", 1'b1, 4'h1, 16'h0010, 32'h0, 4'h4, 1'b1);
        run_op("R10", 1'b1, 4'h2, 16'h0010, 32'h0, 4'h4, 1'b1);
        check("R10", "chained sum", acc_out, 32'h00000200);

        // R1 reset in mid-stream
        run_op("R1", 1'b1, 4'hB, 16'h8000, 32'h0, 4'h0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_acc = 32'h0; m_c = 1'b0; m_t = 1'b0; m_n = 1'b0;
        check_all("R1");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule